// File: doc/BRIEF.md
# Multi-Lane Deskew Alignment FIFO

This block takes several byte streams, each arriving on its own link clock with its own frame marker, and delivers them frame-aligned on a single system read clock. Every lane writes into a small circular buffer in its link domain. The frame marker forces that lane's write address back to location zero. The marker also flips a toggle that is carried into the read domain through a flop chain, so the read domain sees a one-cycle arrival pulse for each lane.

A single alignment controller collects these arrivals. When the latest lane's marker has been seen within the allowed window, it starts every lane's read pointer at location zero on the same cycle. From then on, each output word on every lane belongs to the same position in the frame. If the latest arrival comes too long after the first one, the controller records a skew error and stays idle. Alignment happens by itself once after reset. After that, a new alignment only begins on a resync strobe. The strobe always breaks the output stream: valid drops, the outputs go to zero and a data-hit pulse is raised. Status flags hold until they are cleared.

Top module: `dsk_align_top`

## Requirements
- R1: While rst_ni is low, and on the first cycles after it is released, rd_valid_o, rd_data_o, aligned_o, skew_err_o and data_hit_o are all zero.
- R2: A frame pulse on a lane stores the word that arrives with it at buffer location 0. Once aligned, each lane delivers, in order, its frame-pulse word and then the words that followed it, one per read cycle. Lane i occupies rd_data_o bits [i*DATA_W +: DATA_W].
- R3: This applies when all clocks run together. If the read-clock edge that samples the latest lane's frame pulse is edge k, then aligned_o rises after edge k+3 and rd_valid_o rises after edge k+4, carrying the frame-pulse words.
- R4: A pulse spread of up to MAX_SKEW (default 18) read cycles still aligns. If the latest lane trails the first by more than MAX_SKEW cycles, skew_err_o is set and rd_valid_o stays low.
- R5: Whenever rd_valid_o is low, rd_data_o is all zeros.
- R6: Once aligned, further frame pulses do not restart alignment. rd_valid_o stays high and data_hit_o stays low.
- R7: A resync_i pulse clears rd_valid_o and rd_data_o at the same edge, raises data_hit_o for the following cycle, and re-arms alignment.
- R8: aligned_o and skew_err_o are sticky. Each stays set until sts_clr_i, and a new set event in the same cycle overrides the clear.
- R9: After a skew error, later frame pulses are ignored until resync_i. rd_valid_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset for all domains |
| wr_clk_i | input | NUM_LANES | Per-lane link clocks |
| wr_data_i | input | NUM_LANES*DATA_W | Per-lane incoming words |
| wr_fp_i | input | NUM_LANES | Per-lane frame pulses, link domain |
| rd_clk_i | input | 1 | System read clock |
| resync_i | input | 1 | One-cycle software realignment strobe |
| sts_clr_i | input | 1 | Clears the sticky status flags |
| rd_data_o | output | NUM_LANES*DATA_W | Aligned output words |
| rd_valid_o | output | 1 | Output words are aligned and valid |
| aligned_o | output | 1 | Sticky: alignment completed |
| skew_err_o | output | 1 | Sticky: skew exceeded MAX_SKEW |
| data_hit_o | output | 1 | One-cycle pulse after a resync |

## Verification
Several properties are checked on every cycle by assertions. Zero output while invalid holds at all times. Each accepted resync clears valid and raises the hit pulse. A start is always followed by valid. The halted state never shows valid. The error flag stays sticky, and the write pointer stays inside the buffer. Other behaviour can only be shown by the bench's scenarios, which are compared against a reference model on every clock. These include the exact cycle of alignment for a given pattern of marker arrivals, the boundary between a spread of exactly MAX_SKEW and one more, the word contents delivered per lane, and pulses being ignored after alignment or after an error.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_COLLECT = 2'd1,
    ST_RUN     = 2'd2,
    ST_HALT    = 2'd3
  } align_st_e;
endpackage

// File: rtl/dsk_lane_wr.sv
module dsk_lane_wr #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 24,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fp_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fp_tgl_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q;
  logic [PTR_W-1:0]  wr_addr;
  logic              tgl_q;

  assign wr_addr = fp_i ? '0 : wptr_q;

  always_ff @(posedge clk_i) mem[wr_addr] <= data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      wptr_q <= (wr_addr == LAST) ? '0 : wr_addr + 1'b1;
      tgl_q  <= tgl_q ^ fp_i;
    end
  end

  assign rdata_o  = mem[raddr_i];
  assign fp_tgl_o = tgl_q;

  assert_wptr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_q <= LAST);
endmodule

// File: rtl/dsk_fp_sync.sv
module dsk_fp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], tgl_i};
  end

  // toggle edge after the metastability chain
  assign pulse_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/dsk_align_ctrl.sv
module dsk_align_ctrl
  import dsk_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int MAX_SKEW  = 18,
  localparam int CNT_W    = $clog2(MAX_SKEW + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] arr_i,
  input  logic                 resync_i,
  input  logic                 sts_clr_i,
  output logic                 start_o,
  output logic                 run_o,
  output logic                 aligned_o,
  output logic                 skew_err_o,
  output logic                 data_hit_o
);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(MAX_SKEW - 1);

  align_st_e            st_q;
  logic [NUM_LANES-1:0] seen_q, seen_nx;
  logic [CNT_W-1:0]     cnt_q;
  logic                 start_q, valid_q, aligned_q, err_q, hit_q;
  logic                 set_start, set_err;

  assign seen_nx = seen_q | arr_i;

  always_comb begin
    set_start = 1'b0;
    set_err   = 1'b0;
    if (!resync_i) begin
      unique case (st_q)
        ST_ARMED:   set_start = &arr_i;
        ST_COLLECT: begin
          set_start = &seen_nx;
          set_err   = !(&seen_nx) && (cnt_q == CNT_LIM);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_ARMED;
      seen_q  <= '0;
      cnt_q   <= '0;
      start_q <= 1'b0;
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      start_q <= set_start;
      hit_q   <= resync_i;
      if (resync_i) begin
        st_q    <= ST_ARMED;
        seen_q  <= '0;
        cnt_q   <= '0;
        valid_q <= 1'b0;
      end else begin
        if (start_q) valid_q <= 1'b1;
        unique case (st_q)
          ST_ARMED: if (|arr_i) begin
            seen_q <= arr_i;
            cnt_q  <= '0;
            st_q   <= set_start ? ST_RUN : ST_COLLECT;
          end
          ST_COLLECT: begin
            seen_q <= seen_nx;
            cnt_q  <= cnt_q + 1'b1;
            if (set_start)    st_q <= ST_RUN;
            else if (set_err) st_q <= ST_HALT;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      aligned_q <= set_start | (aligned_q & ~sts_clr_i);
      err_q     <= set_err   | (err_q     & ~sts_clr_i);
    end
  end

  assign start_o    = start_q;
  assign run_o      = valid_q;
  assign aligned_o  = aligned_q;
  assign skew_err_o = err_q;
  assign data_hit_o = hit_q;

  assert_start_then_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q && !resync_i |=> valid_q);
  assert_resync_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (!valid_q && hit_q));
  assert_halt_no_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_HALT |-> !valid_q);
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !sts_clr_i |=> err_q);
endmodule

// File: rtl/dsk_lane_rd.sv
module dsk_lane_rd #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 24,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic              flush_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [PTR_W-1:0]  raddr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  rptr_q;
  logic [DATA_W-1:0] rdata_q;

  assign raddr_o = start_i ? '0 : rptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rdata_q <= '0;
    end else if (flush_i || !(start_i || run_i)) begin
      rptr_q  <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= mem_rdata_i;
      rptr_q  <= (raddr_o == LAST) ? '0 : raddr_o + 1'b1;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dsk_align_top.sv
module dsk_align_top #(
  parameter int NUM_LANES   = 4,
  parameter int DATA_W      = 10,
  parameter int DEPTH       = 24,
  parameter int MAX_SKEW    = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          rst_ni,
  input  logic [NUM_LANES-1:0]          wr_clk_i,
  input  logic [NUM_LANES*DATA_W-1:0]   wr_data_i,
  input  logic [NUM_LANES-1:0]          wr_fp_i,
  input  logic                          rd_clk_i,
  input  logic                          resync_i,
  input  logic                          sts_clr_i,
  output logic [NUM_LANES*DATA_W-1:0]   rd_data_o,
  output logic                          rd_valid_o,
  output logic                          aligned_o,
  output logic                          skew_err_o,
  output logic                          data_hit_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [NUM_LANES-1:0] arr;
  logic                 start, run;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [PTR_W-1:0]  raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              tgl;

    dsk_lane_wr #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
      .clk_i    (wr_clk_i[i]),
      .rst_ni   (rst_ni),
      .data_i   (wr_data_i[i*DATA_W +: DATA_W]),
      .fp_i     (wr_fp_i[i]),
      .raddr_i  (raddr),
      .rdata_o  (mem_rdata),
      .fp_tgl_o (tgl)
    );

    dsk_fp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (rd_clk_i),
      .rst_ni  (rst_ni),
      .tgl_i   (tgl),
      .pulse_o (arr[i])
    );

    dsk_lane_rd #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
      .clk_i       (rd_clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start),
      .run_i       (run),
      .flush_i     (resync_i),
      .mem_rdata_i (mem_rdata),
      .raddr_o     (raddr),
      .rdata_o     (rd_data_o[i*DATA_W +: DATA_W])
    );
  end

  dsk_align_ctrl #(.NUM_LANES(NUM_LANES), .MAX_SKEW(MAX_SKEW)) u_ctrl (
    .clk_i      (rd_clk_i),
    .rst_ni     (rst_ni),
    .arr_i      (arr),
    .resync_i   (resync_i),
    .sts_clr_i  (sts_clr_i),
    .start_o    (start),
    .run_o      (run),
    .aligned_o  (aligned_o),
    .skew_err_o (skew_err_o),
    .data_hit_o (data_hit_o)
  );

  assign rd_valid_o = run;

  assert_idle_zero_R5: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> rd_data_o == '0);
endmodule

// File: tb/dsk_align_top_bench.sv
module dsk_align_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int DW = 10;
  localparam int SKEW = 18;
  localparam int HMAX = 4096;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NL*DW-1:0] wr_data = '0;
  logic [NL-1:0] wr_fp = '0;
  logic resync = 1'b0, sts_clr = 1'b0;
  logic [NL*DW-1:0] rd_data;
  logic rd_valid, aligned, skew_err, data_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsk_align_top u_dsk_align_top (
    .rst_ni(rst_ni), .wr_clk_i({NL{clk}}), .wr_data_i(wr_data), .wr_fp_i(wr_fp),
    .rd_clk_i(clk), .resync_i(resync), .sts_clr_i(sts_clr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .aligned_o(aligned),
    .skew_err_o(skew_err), .data_hit_o(data_hit)
  );

  int n_cmp = 0, n_bad = 0;
  int ecnt = 0;
  logic [DW-1:0] hist [NL][HMAX];
  bit fph [NL][HMAX];
  int fp_a [NL], fp_b [NL], fp_c [NL];

  // reference model state
  int m_st = 0;            // 0 armed, 1 collecting, 2 running, 3 halted
  int m_first = 0, m_s = 0;
  int m_fpk [NL];
  bit m_seen [NL];
  bit m_valid = 0, m_pend = 0, m_al = 0, m_err = 0, m_hit = 0;

  function automatic logic [DW-1:0] word_of(int l, int e);
    return DW'(l * 97 + e * 13 + (e >> 3));
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at edge %0d: actual %0h expected %0h", req, what, ecnt, act, exp);
    end
  endtask

  initial for (int l = 0; l < NL; l++) begin
    fp_a[l] = -1; fp_b[l] = -1; fp_c[l] = -1;
  end

  // model update at each read edge
  always @(posedge clk) begin
    bit arr [NL];
    bit all_in, any_in, st_set, er_set;
    ecnt++;
    if (!rst_ni) begin
      m_st = 0; m_valid = 0; m_pend = 0; m_al = 0; m_err = 0; m_hit = 0;
    end else begin
      st_set = 0; er_set = 0;
      m_hit = resync;
      for (int l = 0; l < NL; l++) arr[l] = (ecnt >= 3) && fph[l][ecnt-3];
      if (resync) begin
        m_st = 0; m_valid = 0; m_pend = 0;
      end else begin
        if (m_pend) begin m_valid = 1; m_pend = 0; end
        any_in = 0; all_in = 1;
        if (m_st == 0) begin
          for (int l = 0; l < NL; l++) begin
            m_seen[l] = arr[l];
            if (arr[l]) begin m_fpk[l] = ecnt - 3; any_in = 1; end
            else all_in = 0;
          end
          if (any_in) begin m_first = ecnt; m_st = all_in ? 2 : 1; st_set = all_in; end
        end else if (m_st == 1) begin
          for (int l = 0; l < NL; l++) begin
            if (arr[l] && !m_seen[l]) begin m_seen[l] = 1; m_fpk[l] = ecnt - 3; end
            if (!m_seen[l]) all_in = 0;
          end
          if (all_in) begin m_st = 2; st_set = 1; end
          else if (ecnt - m_first == SKEW) begin m_st = 3; er_set = 1; end
        end
        if (st_set) begin m_pend = 1; m_s = ecnt + 1; end
      end
      m_al  = st_set | (m_al  & !sts_clr);
      m_err = er_set | (m_err & !sts_clr);
    end
  end

  // compare, then drive inputs for the next edge
  always @(negedge clk) begin
    int e;
    chk("R3", "rd_valid", rd_valid, m_valid);
    chk("R8", "aligned", aligned, m_al);
    chk("R4", "skew_err", skew_err, m_err);
    chk("R7", "data_hit", data_hit, m_hit);
    for (int l = 0; l < NL; l++) begin
      if (m_valid) chk("R2", $sformatf("lane%0d data", l), rd_data[l*DW +: DW],
                       hist[l][m_fpk[l] + ecnt - m_s]);
      else chk("R5", $sformatf("lane%0d idle data", l), rd_data[l*DW +: DW], 0);
    end
    e = ecnt + 1;
    for (int l = 0; l < NL; l++) begin
      wr_data[l*DW +: DW] = word_of(l, e);
      hist[l][e] = word_of(l, e);
      wr_fp[l] = rst_ni && (e == fp_a[l] || e == fp_b[l] || e == fp_c[l]);
      fph[l][e] = wr_fp[l];
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int o0, int o1, int o2, int o3, bit rep);
    int off [NL];
    off = '{o0, o1, o2, o3};
    for (int l = 0; l < NL; l++) begin
      fp_a[l] = ecnt + 4 + off[l];
      fp_b[l] = rep ? fp_a[l] + 48 : -1;
      fp_c[l] = rep ? fp_a[l] + 96 : -1;
    end
  endtask

  task automatic strobe_resync();
    @(negedge clk); #1 resync = 1'b1;
    @(negedge clk); #1 resync = 1'b0;
  endtask

  task automatic strobe_clr();
    @(negedge clk); #1 sts_clr = 1'b1;
    @(negedge clk); #1 sts_clr = 1'b0;
  endtask

  initial begin
    wait_cyc(4);
    chk("R1", "reset valid", rd_valid, 0);
    chk("R1", "reset data", rd_data, 0);
    chk("R1", "reset status", {aligned, skew_err, data_hit}, 0);
    #1 rst_ni = 1'b1;
    wait_cyc(3);
    chk("R1", "post-reset valid", rd_valid, 0);
    // skew of exactly SKEW aligns; repeats at frame multiples of depth
    send(2, 7, 14, 20, 1);
    wait_cyc(160);
    chk("R4", "aligned at max skew", aligned, 1);
    chk("R6", "valid kept over repeat pulses", rd_valid, 1);
    chk("R6", "no hit from repeat pulses", data_hit, 0);
    strobe_clr();
    wait_cyc(2);
    chk("R8", "aligned cleared", aligned, 0);
    chk("R8", "valid unaffected by clear", rd_valid, 1);
    strobe_resync();
    chk("R7", "hit after resync", data_hit, 1);
    chk("R7", "valid dropped", rd_valid, 0);
    wait_cyc(4);
    // one cycle over the limit
    send(0, 19, 5, 3, 0);
    wait_cyc(50);
    chk("R4", "skew error", skew_err, 1);
    chk("R4", "no valid on error", rd_valid, 0);
    send(0, 0, 0, 0, 0);
    wait_cyc(40);
    chk("R9", "halted ignores pulses", rd_valid, 0);
    strobe_resync();
    wait_cyc(4);
    send(0, 0, 0, 0, 0);
    wait_cyc(60);
    chk("R3", "zero-skew align", rd_valid, 1);
    chk("R8", "err still sticky", skew_err, 1);
    strobe_clr();
    wait_cyc(2);
    chk("R8", "err cleared", skew_err, 0);
    strobe_resync();
    wait_cyc(4);
    send(10, 6, 3, 0, 0);
    wait_cyc(80);
    chk("R2", "reverse-order align", rd_valid, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule